// File: doc/BRIEF.md
# Bias Coefficient Start-up and Configuration Sequencer

This block brings up a two-channel, temperature-driven bias code generator and keeps its configuration. When reset is released it clears the output path. It then copies every channel's coefficient set out of a non-volatile word store into volatile operating registers. It holds both DAC codes at zero until two things have happened: the copy is complete and the first temperature sample has been taken. The first sample is taken a fixed number of cycles after reset. After that, each temperature strobe recomputes both channel codes on one clock edge, using a simple banded-sum stub of the interpolation.

A host port reads and writes the operating registers. A write is accepted only at the top access level and only while no load or commit is running. It changes the register at once and is used by the next computation. The change is lost at the next reset unless a commit command first copies all operating words back into the store, one word at a time. A per-channel drive enable puts either the channel code or zero on that channel's drive output.

The store model is cleared to its default contents (all zero) only by a separate power-on input, so committed words survive the block reset. Each channel owns `NUM_SEG+1` consecutive words, with channel c starting at word `c*(NUM_SEG+1)`. The first word of a channel holds, from the top bit down, a bypass flag, a polarity flag and an 8-bit base. The following words hold the band increments in their low 8 bits.

Top module: `bias_cfg_seq`

States and transitions of the sequencer:
- SEQ_CLEAR goes to SEQ_LOAD_RD after one cycle.
- SEQ_LOAD_RD goes to SEQ_LOAD_CAP.
- SEQ_LOAD_CAP goes back to SEQ_LOAD_RD for the next word, or to SEQ_WAIT_TEMP after the last word.
- SEQ_WAIT_TEMP goes to SEQ_RUN once the first sample exists, computing the first codes on that edge.
- SEQ_RUN goes to SEQ_CMT_WR on an accepted commit.
- SEQ_CMT_WR goes to SEQ_CMT_WAIT.
- SEQ_CMT_WAIT goes back to SEQ_CMT_WR for the next word, or to SEQ_RUN after the last word, once the store is no longer busy.

## Requirements
- R1: While reset is asserted and after its release, `dac_code` and `drv_out` are zero until the first computation, and `busy` reads 1 during the clear and load states.
- R2: After reset release the sequencer copies every store word into the operating registers; once `busy` falls, `host_rdata` at each address equals the stored word.
- R3: No code is produced before the coefficient copy has finished and the first temperature sample is taken, FIRST_CONV_CYC clock edges after reset release; the first codes use `temp_in` sampled at that edge and appear one edge later.
- R4: A host write at level 2 (`host_level` = 2'd2) to an address below the word count changes the operating word at once (visible on `host_rdata`), but the DAC codes change only at the next computation.
- R5: Host writes at levels 0, 1 and 3 are ignored.
- R6: Host writes while `busy` is 1 are ignored.
- R7: A `host_commit` pulse at level 2 in the run state copies every operating word into the store; `busy` stays 1 for at least word-count × NV_WR_CYC cycles; committed words come back after a later block reset.
- R8: With default (all-zero) store contents, both codes and both drive outputs are zero for any temperature and any enable.
- R9: `drv_out` of channel c equals that channel's code when `drv_en[c]` is 1 and zero when it is 0.
- R10: After the first sample, each `temp_vld` pulse recomputes both codes on the same edge; temperature strobes before the first sample are ignored, and codes hold between strobes.
- R11: Code = base when bypass (word bit 9) is set. Otherwise code = base plus the increments of every band s with `temp_in` ≥ s·2^(TEMP_W−SEG_W), or minus that sum when polarity (bit 8) is set, modulo 2^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset; clears the data path and restarts the load |
| por_n | input | 1 | Active-low power-on clear of the non-volatile store model |
| temp_in | input | TEMP_W | Temperature sample |
| temp_vld | input | 1 | Strobe for a new temperature sample |
| drv_en | input | NUM_CH | Per-channel drive enable |
| host_wr | input | 1 | Host write request |
| host_addr | input | AW | Operating word address for read and write |
| host_wdata | input | CODE_W+2 | Host write data |
| host_level | input | 2 | Current access level |
| host_commit | input | 1 | Commit command pulse |
| host_rdata | output | CODE_W+2 | Operating word at host_addr |
| busy | output | 1 | Load or commit in progress |
| dac_code | output | NUM_CH*CODE_W | Channel codes, channel 0 in the low bits |
| drv_out | output | NUM_CH*CODE_W | Gated drive codes |

## Verification
The main function is tried with the default all-zero store and with random temperatures and enables, which tells the clear and default paths apart from a real computation. Directed temperatures at 0, at band edges and at full scale, with bypass, polarity and wrapping sums, separate the band selection and sign handling. Fully random coefficient and temperature mixes then cover the general case. A reset between a commit and later uncommitted host writes shows whether the store or the volatile registers supply the reloaded values, and a strobe placed before the first sample shows whether early strobes leak into the output.

// File: rtl/bias_cfg_pkg.sv
package bias_cfg_pkg;

    typedef enum logic [2:0] {
        SEQ_CLEAR,
        SEQ_LOAD_RD,
        SEQ_LOAD_CAP,
        SEQ_WAIT_TEMP,
        SEQ_RUN,
        SEQ_CMT_WR,
        SEQ_CMT_WAIT
    } seq_state_t;

    localparam logic [1:0] LEVEL_WRITE = 2'd2;

endpackage

// File: rtl/bias_nv_store.sv
module bias_nv_store #(
    parameter int DEPTH  = 10,
    parameter int WIDTH  = 10,
    parameter int WR_CYC = 4,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_busy
);
    localparam int CW = $clog2(WR_CYC + 1);

    logic [WIDTH-1:0] cell_q [DEPTH];
    logic [CW-1:0]    busy_cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
            rd_data    <= '0;
            busy_cnt_q <= '0;
        end else begin
            if (rd_en) rd_data <= cell_q[rd_addr];
            if (wr_en && busy_cnt_q == '0) begin
                cell_q[wr_addr] <= wr_data;
                busy_cnt_q      <= CW'(WR_CYC);
            end else if (busy_cnt_q != '0) begin
                busy_cnt_q <= busy_cnt_q - 1'b1;
            end
        end
    end

    assign wr_busy = (busy_cnt_q != '0);

endmodule

// File: rtl/bias_op_regs.sv
module bias_op_regs #(
    parameter int DEPTH = 10,
    parameter int WIDTH = 10,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [WIDTH-1:0]       wdata,
    input  logic [AW-1:0]          raddr,
    output logic [WIDTH-1:0]       rdata,
    output logic [DEPTH*WIDTH-1:0] words
);
    logic [WIDTH-1:0] reg_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) reg_q[i] <= '0;
        end else if (we) begin
            reg_q[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? reg_q[raddr] : '0;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign words[g*WIDTH +: WIDTH] = reg_q[g];
    end

endmodule

// File: rtl/bias_band_calc.sv
module bias_band_calc #(
    parameter int CODE_W = 8,
    parameter int TEMP_W = 8,
    parameter int SEG_W  = 2,
    parameter int NUM_SEG = 1 << SEG_W,
    parameter int WORD_W = CODE_W + 2
) (
    input  logic [WORD_W-1:0]         head_word,
    input  logic [NUM_SEG*CODE_W-1:0] incs,
    input  logic [TEMP_W-1:0]         temp,
    output logic [CODE_W-1:0]         code
);
    localparam int BAND = 1 << (TEMP_W - SEG_W);

    logic              bypass, negate;
    logic [CODE_W-1:0] base, acc;

    assign bypass = head_word[WORD_W-1];
    assign negate = head_word[WORD_W-2];
    assign base   = head_word[CODE_W-1:0];

    always_comb begin
        acc = '0;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (temp >= TEMP_W'(s * BAND)) acc = acc + incs[s*CODE_W +: CODE_W];
        end
        if (bypass)      code = base;
        else if (negate) code = base - acc;
        else             code = base + acc;
    end

endmodule

// File: rtl/bias_cfg_seq.sv
module bias_cfg_seq #(
    parameter int NUM_CH         = 2,
    parameter int CODE_W         = 8,
    parameter int TEMP_W         = 8,
    parameter int SEG_W          = 2,
    parameter int FIRST_CONV_CYC = 2500000,
    parameter int NV_WR_CYC      = 4,
    parameter int NUM_SEG        = 1 << SEG_W,
    parameter int WPC            = NUM_SEG + 1,
    parameter int DEPTH          = NUM_CH * WPC,
    parameter int AW             = $clog2(DEPTH),
    parameter int WORD_W         = CODE_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     por_n,
    input  logic [TEMP_W-1:0]        temp_in,
    input  logic                     temp_vld,
    input  logic [NUM_CH-1:0]        drv_en,
    input  logic                     host_wr,
    input  logic [AW-1:0]            host_addr,
    input  logic [WORD_W-1:0]        host_wdata,
    input  logic [1:0]               host_level,
    input  logic                     host_commit,
    output logic [WORD_W-1:0]        host_rdata,
    output logic                     busy,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH*CODE_W-1:0] drv_out
);
    import bias_cfg_pkg::*;

    localparam int          TW       = $clog2(FIRST_CONV_CYC + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    seq_state_t state_q, state_d;

    logic [AW-1:0]             idx_q;
    logic [TW-1:0]             tmr_q;
    logic                      conv_seen_q;
    logic [TEMP_W-1:0]         temp_hold_q;
    logic                      live_q;
    logic [NUM_CH-1:0][CODE_W-1:0] dac_q;

    logic                      nv_rd_en, nv_wr_en, nv_busy;
    logic [WORD_W-1:0]         nv_rd_data, nv_wr_data;
    logic                      reg_we, host_ok, load_cap, commit_ok;
    logic [AW-1:0]             reg_waddr;
    logic [WORD_W-1:0]         reg_wdata;
    logic [DEPTH*WORD_W-1:0]   op_flat;
    logic [TEMP_W-1:0]         temp_sel;
    logic                      first_calc, next_calc;
    logic [NUM_CH-1:0][CODE_W-1:0] calc_code;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_CLEAR;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_CLEAR:     state_d = SEQ_LOAD_RD;
            SEQ_LOAD_RD:   state_d = SEQ_LOAD_CAP;
            SEQ_LOAD_CAP:  state_d = (idx_q == LAST_IDX) ? SEQ_WAIT_TEMP : SEQ_LOAD_RD;
            SEQ_WAIT_TEMP: if (conv_seen_q) state_d = SEQ_RUN;
            SEQ_RUN:       if (commit_ok) state_d = SEQ_CMT_WR;
            SEQ_CMT_WR:    state_d = SEQ_CMT_WAIT;
            SEQ_CMT_WAIT:  if (!nv_busy) state_d = (idx_q == LAST_IDX) ? SEQ_RUN : SEQ_CMT_WR;
            default:       state_d = SEQ_CLEAR;
        endcase
    end

    // ---------------- decoded controls ----------------
    assign busy      = (state_q == SEQ_CLEAR) || (state_q == SEQ_LOAD_RD) ||
                       (state_q == SEQ_LOAD_CAP) || (state_q == SEQ_CMT_WR) ||
                       (state_q == SEQ_CMT_WAIT);
    assign load_cap  = (state_q == SEQ_LOAD_CAP);
    assign host_ok   = host_wr && (host_level == LEVEL_WRITE) && !busy &&
                       (int'(host_addr) < DEPTH);
    assign commit_ok = host_commit && (host_level == LEVEL_WRITE) && (state_q == SEQ_RUN);
    assign reg_we    = load_cap || host_ok;
    assign reg_waddr = load_cap ? idx_q : host_addr;
    assign reg_wdata = load_cap ? nv_rd_data : host_wdata;
    assign nv_rd_en  = (state_q == SEQ_LOAD_RD);
    assign nv_wr_en  = (state_q == SEQ_CMT_WR);
    assign nv_wr_data = op_flat[idx_q*WORD_W +: WORD_W];

    assign first_calc = (state_q == SEQ_WAIT_TEMP) && conv_seen_q;
    assign next_calc  = live_q && temp_vld &&
                        ((state_q == SEQ_RUN) || (state_q == SEQ_CMT_WR) ||
                         (state_q == SEQ_CMT_WAIT));
    assign temp_sel   = live_q ? temp_in : temp_hold_q;

    // ---------------- outputs and data registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            tmr_q       <= '0;
            conv_seen_q <= 1'b0;
            temp_hold_q <= '0;
            live_q      <= 1'b0;
            dac_q       <= '0;
        end else begin
            if (!conv_seen_q) begin
                tmr_q <= tmr_q + 1'b1;
                if (tmr_q == TW'(FIRST_CONV_CYC - 1)) begin
                    conv_seen_q <= 1'b1;
                    temp_hold_q <= temp_in;
                end
            end
            if (load_cap || ((state_q == SEQ_CMT_WAIT) && !nv_busy))
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            if (first_calc || next_calc) begin
                dac_q  <= calc_code;
                live_q <= 1'b1;
            end
        end
    end

    // ---------------- storage ----------------
    bias_nv_store #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W),
        .WR_CYC(NV_WR_CYC),
        .AW    (AW)
    ) u_store (
        .clk    (clk),
        .por_n  (por_n),
        .rd_en  (nv_rd_en),
        .rd_addr(idx_q),
        .rd_data(nv_rd_data),
        .wr_en  (nv_wr_en),
        .wr_addr(idx_q),
        .wr_data(nv_wr_data),
        .wr_busy(nv_busy)
    );

    bias_op_regs #(
        .DEPTH(DEPTH),
        .WIDTH(WORD_W),
        .AW   (AW)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .waddr(reg_waddr),
        .wdata(reg_wdata),
        .raddr(host_addr),
        .rdata(host_rdata),
        .words(op_flat)
    );

    // ---------------- per-channel computation and gating ----------------
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_SEG*CODE_W-1:0] incs;
        for (genvar s = 0; s < NUM_SEG; s++) begin : g_inc
            assign incs[s*CODE_W +: CODE_W] = op_flat[(c*WPC+1+s)*WORD_W +: CODE_W];
        end

        bias_band_calc #(
            .CODE_W (CODE_W),
            .TEMP_W (TEMP_W),
            .SEG_W  (SEG_W),
            .NUM_SEG(NUM_SEG),
            .WORD_W (WORD_W)
        ) u_calc (
            .head_word(op_flat[c*WPC*WORD_W +: WORD_W]),
            .incs     (incs),
            .temp     (temp_sel),
            .code     (calc_code[c])
        );

        assign dac_code[c*CODE_W +: CODE_W] = dac_q[c];
        assign drv_out[c*CODE_W +: CODE_W]  = drv_en[c] ? dac_q[c] : '0;
    end

endmodule

// File: rtl/bias_cfg_seq_chk.sv
module bias_cfg_seq_chk #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 8,
    parameter int DEPTH  = 10,
    parameter int WORD_W = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input bias_cfg_pkg::seq_state_t  state_q,
    input logic                      live_q,
    input logic                      host_wr,
    input logic [1:0]                host_level,
    input logic                      temp_vld,
    input logic [NUM_CH*CODE_W-1:0]  dac_code,
    input logic [DEPTH*WORD_W-1:0]   op_flat,
    input logic                      nv_wr_en,
    input logic                      nv_busy
);
    import bias_cfg_pkg::*;

    logic in_load, in_cmt, idle_ok;
    assign in_load = (state_q == SEQ_CLEAR) || (state_q == SEQ_LOAD_RD) || (state_q == SEQ_LOAD_CAP);
    assign in_cmt  = (state_q == SEQ_CMT_WR) || (state_q == SEQ_CMT_WAIT);
    assign idle_ok = (state_q == SEQ_RUN) || (state_q == SEQ_WAIT_TEMP);

    AST_ZERO_BEFORE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> dac_code == '0);  // R1

    AST_LOAD_NOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_load |-> !live_q);  // R3

    AST_LOW_LEVEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_level != LEVEL_WRITE && idle_ok) |=> $stable(op_flat));  // R5

    AST_COMMIT_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmt |=> $stable(op_flat));  // R6

    AST_STORE_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_en |-> !nv_busy);  // R7

    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !temp_vld) |=> $stable(dac_code));  // R10

endmodule

bind bias_cfg_seq bias_cfg_seq_chk #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W),
    .DEPTH (DEPTH),
    .WORD_W(WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .live_q    (live_q),
    .host_wr   (host_wr),
    .host_level(host_level),
    .temp_vld  (temp_vld),
    .dac_code  (dac_code),
    .op_flat   (op_flat),
    .nv_wr_en  (nv_wr_en),
    .nv_busy   (nv_busy)
);

// File: tb/bias_cfg_seq_bench.sv
module bias_cfg_seq_bench;

    localparam int NCH = 2;
    localparam int CW  = 8;
    localparam int TW  = 8;
    localparam int WW  = 10;
    localparam int WPC = 5;
    localparam int DEP = 10;
    localparam int AW  = 4;
    localparam int FCC = 40;
    localparam int NWC = 3;

    logic               clk, rst_n, por_n;
    logic [TW-1:0]      temp_in;
    logic               temp_vld;
    logic [NCH-1:0]     drv_en;
    logic               host_wr;
    logic [AW-1:0]      host_addr;
    logic [WW-1:0]      host_wdata;
    logic [1:0]         host_level;
    logic               host_commit;
    logic [WW-1:0]      host_rdata;
    logic               busy;
    logic [NCH*CW-1:0]  dac_code, drv_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [WW-1:0] exp_ops [DEP];
    logic [WW-1:0] exp_nv  [DEP];
    logic [CW-1:0] exp_dac [NCH];

    bias_cfg_seq #(
        .NUM_CH(NCH), .CODE_W(CW), .TEMP_W(TW), .SEG_W(2),
        .FIRST_CONV_CYC(FCC), .NV_WR_CYC(NWC)
    ) u_bias_cfg_seq (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .temp_in(temp_in), .temp_vld(temp_vld),
        .drv_en(drv_en), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_level(host_level), .host_commit(host_commit), .host_rdata(host_rdata),
        .busy(busy), .dac_code(dac_code), .drv_out(drv_out)
    );

    initial begin
        clk = 0;
        forever #5 clk = ~clk;
    end

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: act=running exp=finished");
        summary();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] calc(input int c, input logic [TW-1:0] t);
        logic [WW-1:0] hw;
        logic [CW-1:0] sum;
        hw  = exp_ops[c*WPC];
        sum = '0;
        for (int s = 0; s < 4; s++) if (int'(t) >= s * 64) sum = sum + exp_ops[c*WPC+1+s][CW-1:0];
        if (hw[9]) return hw[CW-1:0];
        if (hw[8]) return hw[CW-1:0] - sum;
        return hw[CW-1:0] + sum;
    endfunction

    task automatic host_write(input int a, input logic [WW-1:0] d, input logic [1:0] lvl);
        @(negedge clk);
        host_wr = 1; host_addr = AW'(a); host_wdata = d; host_level = lvl;
        @(negedge clk);
        host_wr = 0; host_level = 2'd2;
    endtask

    task automatic read_word(input int a, output logic [WW-1:0] d);
        host_addr = AW'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic strobe(input logic [TW-1:0] t);
        @(negedge clk);
        temp_in = t; temp_vld = 1;
        @(negedge clk);
        temp_vld = 0;
        for (int c = 0; c < NCH; c++) exp_dac[c] = calc(c, t);
    endtask

    task automatic check_outputs(input string req);
        drv_en = NCH'($urandom);
        #1;
        for (int c = 0; c < NCH; c++) begin
            check(req, dac_code[c*CW +: CW], exp_dac[c]);
            check({req, " R9"}, drv_out[c*CW +: CW], drv_en[c] ? exp_dac[c] : '0);
        end
    endtask

    task automatic check_regs(input string req);
        logic [WW-1:0] d;
        for (int a = 0; a < DEP; a++) begin
            read_word(a, d);
            check(req, d, exp_ops[a]);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        logic [WW-1:0] d;
        int busy_cycles;
        void'($urandom(32'h1F2E3D));
        por_n = 0; rst_n = 0; temp_in = 0; temp_vld = 0; drv_en = 0;
        host_wr = 0; host_addr = 0; host_wdata = 0; host_level = 2'd2; host_commit = 0;
        for (int a = 0; a < DEP; a++) begin exp_ops[a] = '0; exp_nv[a] = '0; end
        for (int c = 0; c < NCH; c++) exp_dac[c] = '0;

        repeat (3) @(negedge clk);
        #1;
        check("R1 reset dac", dac_code, 0);
        check("R1 reset drv", drv_out, 0);
        por_n = 1; rst_n = 1;
        @(negedge clk);
        check("R1 busy after release", busy, 1);
        check_outputs("R1 after release");

        // default store contents
        wait_idle();
        check_regs("R2 default load");
        temp_in = 8'hC3;
        wait_cyc(FCC + 2);
        check_outputs("R8 first sample defaults");
        for (int i = 0; i < 8; i++) begin
            strobe(8'($urandom));
            check_outputs("R8 zero defaults");
        end

        // directed coefficients
        exp_ops[0] = {1'b0, 1'b1, 8'h10};
        exp_ops[1] = 10'h005; exp_ops[2] = 10'h007; exp_ops[3] = 10'h009; exp_ops[4] = 10'h0F0;
        exp_ops[5] = {1'b1, 1'b0, 8'hA5};
        exp_ops[6] = 10'h011; exp_ops[7] = 10'h022; exp_ops[8] = 10'h033; exp_ops[9] = 10'h044;
        for (int a = 0; a < DEP; a++) host_write(a, exp_ops[a], 2'd2);
        check_regs("R4 host write visible");
        check_outputs("R4 codes unchanged until compute");
        strobe(8'h00);  check_outputs("R11 band0 polarity");
        strobe(8'h3F);  check_outputs("R11 below band1");
        strobe(8'h40);  check_outputs("R11 band1 edge");
        strobe(8'hFF);  check_outputs("R11 full scale wrap");
        exp_ops[5] = {1'b0, 1'b0, 8'hF0};
        host_write(5, exp_ops[5], 2'd2);
        check_outputs("R4 no change on write");
        strobe(8'h80);  check_outputs("R11 add wrap");

        // random coefficients and temperatures
        for (int i = 0; i < 30; i++) begin
            int a;
            a = $urandom_range(DEP - 1);
            exp_ops[a] = WW'($urandom);
            host_write(a, exp_ops[a], 2'd2);
            strobe(8'($urandom));
            check_outputs("R10 random recompute");
        end

        // writes at lower or reserved levels
        for (int lv = 0; lv < 4; lv++) begin
            if (lv == 2) continue;
            host_write(lv, ~exp_ops[lv], 2'(lv));
            read_word(lv, d);
            check("R5 level write ignored", d, exp_ops[lv]);
            strobe(8'($urandom));
            check_outputs("R5 codes use old value");
        end

        // commit
        for (int a = 0; a < DEP; a++) exp_nv[a] = exp_ops[a];
        @(negedge clk);
        host_commit = 1;
        @(negedge clk);
        host_commit = 0;
        check("R7 busy during commit", busy, 1);
        host_wr = 1; host_addr = 0; host_wdata = ~exp_ops[0];
        @(negedge clk);
        host_wr = 0;
        busy_cycles = 2;
        while (busy) begin @(negedge clk); busy_cycles++; end
        check("R7 commit length", (busy_cycles >= DEP * NWC), 1);
        read_word(0, d);
        check("R6 busy write ignored", d, exp_ops[0]);

        // uncommitted changes then block reset
        for (int a = 0; a < DEP; a++) host_write(a, WW'($urandom), 2'd2);
        @(negedge clk);
        rst_n = 0;
        #1;
        check("R1 reset clears codes", dac_code, 0);
        @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < NCH; c++) exp_dac[c] = '0;
        for (int a = 0; a < DEP; a++) exp_ops[a] = exp_nv[a];
        @(negedge clk);
        check("R1 busy on reload", busy, 1);
        wait_idle();
        check_regs("R2 R7 reload from store");
        wait_cyc(FCC - 10);
        strobe(8'h15);
        for (int c = 0; c < NCH; c++) exp_dac[c] = '0;
        check_outputs("R10 early strobe ignored");
        wait_cyc(FCC - 5);
        temp_in = 8'hB7;
        wait_cyc(FCC - 2);
        check_outputs("R3 no code before first sample");
        wait_cyc(FCC + 3);
        temp_in = 8'h02;
        for (int c = 0; c < NCH; c++) exp_dac[c] = calc(c, 8'hB7);
        check_outputs("R3 first code from held sample");
        strobe(8'h02);
        check_outputs("R10 recompute after reload");

        // power-on clear returns defaults
        @(negedge clk);
        por_n = 0; rst_n = 0;
        @(negedge clk);
        por_n = 1; rst_n = 1;
        for (int a = 0; a < DEP; a++) exp_ops[a] = '0;
        for (int c = 0; c < NCH; c++) exp_dac[c] = '0;
        wait_idle();
        check_regs("R8 store default after power-on");
        temp_in = 8'hFF;
        wait_cyc(FCC + 2);
        check_outputs("R8 zero after power-on");

        summary();
    end

endmodule